// File: doc/BRIEF.md
# Multi-Mode PWM and Capture Timer Channel

This block is one timer channel built around a single prescaled counter, `CNT_W` bits wide (16 by default). Software picks one of three modes. In 16-bit PWM mode the whole counter runs as a single pulse-width modulator. In split PWM mode the low half and the high half run as two independent modulators. In capture mode the counter runs free and edges on two input pins copy its running value into the two compare registers. Each mode drives the same four event strobes (A, B, C, D). A separate interrupt block latches these strobes.

Software reaches the channel through a word-wide register port. A write is taken only when every byte lane is enabled. A read is combinational and works at any time. Two further inputs change how the channel behaves:
- `lowpwr` parks the prescaler and the counter, and locks the count and compare registers against writes.
- `freeze` halts counting and discards capture edges for as long as it is high. Counting resumes from the held value when it drops.

Top module: `pwmcap_timer`

## Requirements
- R1: After reset all six registers read 0, and `evt`, `tio0_out` and `tio1_out` are 0. Register addresses: 0 control, 1 prescale, 2 edge select, 3 count, 4 period, 5 duty.
- R2: While control bit 2 (run) is 1, the counter takes one step every PRESCALE+1 clock cycles. While run is 0 the count holds, and the prescale phase restarts from zero.
- R3: With control bits [1:0]=0 (16-bit PWM), the count steps 0..PERIOD and then reloads to 0. `tio0_out` is high while count < DUTY. `evt[0]` pulses on a step taken at count==DUTY, and `evt[1]` pulses on a step taken at count==PERIOD. `evt[3:2]` and `tio1_out` stay 0.
- R4: With control bits [1:0]=1 (split PWM), each counter half steps against its own half of PERIOD and DUTY and reloads on its own. The strobes map as follows: `evt[0]` low-half duty match, `evt[1]` low-half period match, `evt[2]` high-half duty match, `evt[3]` high-half period match. `tio0_out` and `tio1_out` are the low-half and high-half outputs.
- R5: With control bits [1:0]=2 (capture), the counter steps freely. Each pin passes through a 2-flop synchronizer and an edge detector. Pin selects sit in the edge register: bits [1:0] for pin 0 and bits [3:2] for pin 1, with codes 0 off, 1 rising, 2 falling, 3 both. A selected edge on pin 0 copies the count into DUTY and pulses `evt[0]`; one on pin 1 copies it into PERIOD and pulses `evt[1]`. For a pin change made after clock edge m, the captured value is the count held after edge m+2.
- R6: In capture mode, control bit 3 restarts the counter from 0 on a pin-0 capture, and bit 4 does the same on a pin-1 capture.
- R7: In capture mode, a step taken at the all-ones count wraps the counter to 0 and pulses `evt[2]`. `evt[3]` never pulses in this mode.
- R8: While `lowpwr` is high the count and the prescale phase hold. Writes to the control, prescale and edge registers still take effect.
- R9: While `lowpwr` is high, writes to the count, period and duty registers are ignored.
- R10: While `freeze` is high the count holds, no step-driven strobes occur, and capture edges are discarded. After release, counting resumes from the held value.
- R11: A write with any byte-enable bit low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables; a write needs all of them set |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| lowpwr | input | 1 | Low-power park request |
| freeze | input | 1 | Debug halt of counting and capture |
| tio0_in | input | 1 | Capture pin 0 (asynchronous) |
| tio1_in | input | 1 | Capture pin 1 (asynchronous) |
| tio0_out | output | 1 | PWM output (16-bit mode or low half) |
| tio1_out | output | 1 | PWM output of the high half in split mode |
| evt | output | 4 | Event strobes A..D, bit 0 = A |

## Verification
A wrong counter or prescaler state appears on the count register within one step. It also moves the `evt` strobes and the PWM duty share. For this reason the count is read back every cycle over whole periods, which catches an off-by-one reload or a misplaced step at once. A synchronizer that is one stage too deep or too shallow changes the captured value by one count. A lost gating term under `lowpwr` or `freeze` shows as a count that moves, or as a register value that changes while it should be locked. Each of these appears by the next read.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;

   typedef enum logic [1:0] {
      MD_PWM16 = 2'd0,
      MD_SPLIT = 2'd1,
      MD_CAPT  = 2'd2,
      MD_RSVD  = 2'd3
   } tmr_mode_e;

   typedef enum logic [1:0] {
      EG_OFF  = 2'd0,
      EG_RISE = 2'd1,
      EG_FALL = 2'd2,
      EG_BOTH = 2'd3
   } edge_sel_e;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_PSC   = 3'd1;
   localparam logic [2:0] RA_EDGE  = 3'd2;
   localparam logic [2:0] RA_COUNT = 3'd3;
   localparam logic [2:0] RA_PER   = 3'd4;
   localparam logic [2:0] RA_DUTY  = 3'd5;

   localparam int CTRL_W       = 5;
   localparam int CTRL_RUN     = 2;
   localparam int CTRL_RST_A   = 3;
   localparam int CTRL_RST_B   = 4;
   localparam int EDGE_W       = 4;

endpackage

// File: rtl/pwmcap_prescaler.sv
module pwmcap_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [PSC_W-1:0] psc_val,
   output logic             tick
);

   logic [PSC_W-1:0] pcnt;
   logic             at_lim;

   generate
      if (PSC_W < 1) begin : g_bad_w
         $error("pwmcap_prescaler: PSC_W must be at least 1");
      end
   endgenerate

   assign at_lim = (pcnt == psc_val);
   assign tick   = run && !hold && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
      end else if (!hold) begin
         pcnt <= at_lim ? '0 : pcnt + PSC_W'(1);
      end
   end

   // R2
   tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pcnt == '0));

   // R2
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pcnt == '0));

   // R8
   park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hold) |=> $stable(pcnt));

endmodule

// File: rtl/pwmcap_edge.sv
module pwmcap_edge
   import pwmcap_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      pulse
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;
   logic                   rise;
   logic                   fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwmcap_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl  = sync_q[SYNC_STAGES-1];
   assign rise = lvl && !prev_q;
   assign fall = !lvl && prev_q;

   always_comb begin
      case (sel)
         EG_RISE: pulse = rise;
         EG_FALL: pulse = fall;
         EG_BOTH: pulse = rise || fall;
         default: pulse = 1'b0;
      endcase
   end

   // R5
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && sel == EG_RISE) |=> !(pulse && sel == EG_RISE));

   // R5
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && sel == EG_FALL) |=> !(pulse && sel == EG_FALL));

endmodule

// File: rtl/pwmcap_core.sv
module pwmcap_core
   import pwmcap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_mode_e        mode,
   input  logic             tick,
   input  logic             freeze,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             restart,
   input  logic             cap_a,
   input  logic             cap_b,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty,
   output logic [CNT_W-1:0] cnt,
   output logic [3:0]       evt,
   output logic             out0,
   output logic             out1
);

   localparam int HW = CNT_W / 2;

   logic            step;
   logic            full_dm;
   logic            full_pm;
   logic            full_lt;
   logic            at_top;
   logic [1:0]      half_dm;
   logic [1:0]      half_pm;
   logic [1:0]      half_lt;
   logic [HW-1:0]   half_nx [2];

   generate
      if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_w
         $error("pwmcap_core: CNT_W must be even and at least 4");
      end
   endgenerate

   assign step    = tick && !freeze;
   assign full_dm = (cnt == duty);
   assign full_pm = (cnt == period);
   assign full_lt = (cnt < duty);
   assign at_top  = (cnt == '1);

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         logic [HW-1:0] c_s;
         logic [HW-1:0] p_s;
         logic [HW-1:0] d_s;
         assign c_s        = cnt[h*HW +: HW];
         assign p_s        = period[h*HW +: HW];
         assign d_s        = duty[h*HW +: HW];
         assign half_dm[h] = (c_s == d_s);
         assign half_pm[h] = (c_s == p_s);
         assign half_lt[h] = (c_s < d_s);
         assign half_nx[h] = half_pm[h] ? '0 : c_s + HW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt_we) begin
         cnt <= cnt_wdata;
      end else if (restart) begin
         cnt <= '0;
      end else if (step) begin
         case (mode)
            MD_PWM16: cnt <= full_pm ? '0 : cnt + CNT_W'(1);
            MD_SPLIT: cnt <= {half_nx[1], half_nx[0]};
            MD_CAPT:  cnt <= cnt + CNT_W'(1);
            default:  cnt <= cnt;
         endcase
      end
   end

   always_comb begin
      evt  = 4'b0000;
      out0 = 1'b0;
      out1 = 1'b0;
      case (mode)
         MD_PWM16: begin
            evt[0] = step && full_dm;
            evt[1] = step && full_pm;
            out0   = full_lt;
         end
         MD_SPLIT: begin
            evt[0] = step && half_dm[0];
            evt[1] = step && half_pm[0];
            evt[2] = step && half_dm[1];
            evt[3] = step && half_pm[1];
            out0   = half_lt[0];
            out1   = half_lt[1];
         end
         MD_CAPT: begin
            evt[0] = cap_a;
            evt[1] = cap_b;
            evt[2] = step && at_top;
         end
         default: begin
            evt = 4'b0000;
         end
      endcase
   end

   // R10
   frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !cnt_we && !restart) |=> $stable(cnt));

   // R3
   pwm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PWM16 && evt[1] && !cnt_we) |=> (cnt == '0));

   // R4
   split_low_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SPLIT && evt[1] && !cnt_we) |=> (cnt[HW-1:0] == '0));

   // R7
   ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_CAPT && evt[2] && !cnt_we && !restart) |=> (cnt == '0));

endmodule

// File: rtl/pwmcap_timer.sv
module pwmcap_timer
   import pwmcap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         bus_addr,
   input  logic               bus_wr,
   input  logic [CNT_W/8-1:0] bus_be,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   input  logic               lowpwr,
   input  logic               freeze,
   input  logic               tio0_in,
   input  logic               tio1_in,
   output logic               tio0_out,
   output logic               tio1_out,
   output logic [3:0]         evt
);

   localparam int NPIN = 2;

   logic [CTRL_W-1:0] ctrl_q;
   logic [PSC_W-1:0]  psc_q;
   logic [EDGE_W-1:0] edge_q;
   logic [CNT_W-1:0]  per_q;
   logic [CNT_W-1:0]  duty_q;
   logic [CNT_W-1:0]  cnt;

   logic              wr_ok;
   logic              wr_locked_ok;
   tmr_mode_e         mode;
   logic              tick;
   logic              cap_en;
   logic              cap_a;
   logic              cap_b;
   logic              restart;
   logic [NPIN-1:0]   pin_in;
   logic [NPIN-1:0]   pin_pulse;

   generate
      if ((CNT_W % 8) != 0 || CNT_W < 16) begin : g_bad_cnt
         $error("pwmcap_timer: CNT_W must be a multiple of 8, at least 16");
      end
      if (PSC_W >= CNT_W) begin : g_bad_psc
         $error("pwmcap_timer: PSC_W must be narrower than CNT_W");
      end
   endgenerate

   assign mode         = tmr_mode_e'(ctrl_q[1:0]);
   assign wr_ok        = bus_wr && (bus_be == '1);
   assign wr_locked_ok = wr_ok && !lowpwr;
   assign pin_in       = {tio1_in, tio0_in};

   // software-side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         psc_q  <= '0;
         edge_q <= '0;
      end else if (wr_ok) begin
         case (bus_addr)
            RA_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
            RA_PSC:  psc_q  <= bus_wdata[PSC_W-1:0];
            RA_EDGE: edge_q <= bus_wdata[EDGE_W-1:0];
            default: ;
         endcase
      end
   end

   // compare / capture registers: capture wins over a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
         per_q  <= '0;
      end else begin
         if (cap_a) begin
            duty_q <= cnt;
         end else if (wr_locked_ok && bus_addr == RA_DUTY) begin
            duty_q <= bus_wdata;
         end
         if (cap_b) begin
            per_q <= cnt;
         end else if (wr_locked_ok && bus_addr == RA_PER) begin
            per_q <= bus_wdata;
         end
      end
   end

   pwmcap_prescaler #(
      .PSC_W   (PSC_W)
   ) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q[CTRL_RUN]),
      .hold    (lowpwr || freeze),
      .psc_val (psc_q),
      .tick    (tick)
   );

   generate
      for (genvar p = 0; p < NPIN; p++) begin : g_pin
         pwmcap_edge #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[p]),
            .sel   (edge_sel_e'(edge_q[2*p +: 2])),
            .pulse (pin_pulse[p])
         );
      end
   endgenerate

   assign cap_en  = (mode == MD_CAPT) && !freeze && !lowpwr;
   assign cap_a   = cap_en && pin_pulse[0];
   assign cap_b   = cap_en && pin_pulse[1];
   assign restart = (cap_a && ctrl_q[CTRL_RST_A]) || (cap_b && ctrl_q[CTRL_RST_B]);

   pwmcap_core #(
      .CNT_W     (CNT_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .tick      (tick),
      .freeze    (freeze),
      .cnt_we    (wr_locked_ok && bus_addr == RA_COUNT),
      .cnt_wdata (bus_wdata),
      .restart   (restart),
      .cap_a     (cap_a),
      .cap_b     (cap_b),
      .period    (per_q),
      .duty      (duty_q),
      .cnt       (cnt),
      .evt       (evt),
      .out0      (tio0_out),
      .out1      (tio1_out)
   );

   always_comb begin
      case (bus_addr)
         RA_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
         RA_PSC:   bus_rdata = {{(CNT_W-PSC_W){1'b0}}, psc_q};
         RA_EDGE:  bus_rdata = {{(CNT_W-EDGE_W){1'b0}}, edge_q};
         RA_COUNT: bus_rdata = cnt;
         RA_PER:   bus_rdata = per_q;
         RA_DUTY:  bus_rdata = duty_q;
         default:  bus_rdata = '0;
      endcase
   end

   // R8
   lp_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr |=> $stable(cnt));

   // R9
   lp_cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr |=> ($stable(per_q) && $stable(duty_q)));

   // R11
   part_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_be != '1) |=> ($stable(ctrl_q) && $stable(psc_q) && $stable(edge_q)));

endmodule

// File: tb/pwmcap_timer_bench.sv
module pwmcap_timer_bench;
   import pwmcap_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_be = 2'b11;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        lowpwr = 1'b0;
   logic        freeze = 1'b0;
   logic        tio0_in = 1'b0;
   logic        tio1_in = 1'b0;
   logic        tio0_out;
   logic        tio1_out;
   logic [3:0]  evt;

   int n_chk = 0;
   int n_fail = 0;

   pwmcap_timer u_pwmcap_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .lowpwr(lowpwr), .freeze(freeze), .tio0_in(tio0_in), .tio1_in(tio1_in),
      .tio0_out(tio0_out), .tio1_out(tio1_out), .evt(evt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_be    = be;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_be    = 2'b11;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      bus_addr = a;
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic halt_clear();
      wr(RA_CTRL, 16'h0000);
      wr(RA_COUNT, 16'h0000);
   endtask

   task automatic t_reset();
      int v;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk($sformatf("R1 reg %0d after reset", a), v, 0);
      end
      chk("R1 evt after reset", int'(evt), 0);
      chk("R1 outputs after reset", int'({tio1_out, tio0_out}), 0);
   endtask

   task automatic t_pwm16();
      int v, bad = 0, hi = 0, na = 0, nb = 0, ncd = 0, n1 = 0;
      halt_clear();
      wr(RA_PER, 16'd9);
      wr(RA_DUTY, 16'd3);
      wr(RA_CTRL, 16'h0004);
      for (int i = 0; i < 30; i++) begin
         rd(RA_COUNT, v);
         if (v != i % 10) bad++;
         hi  += int'(tio0_out);
         n1  += int'(tio1_out);
         na  += int'(evt[0]);
         nb  += int'(evt[1]);
         ncd += int'(evt[2]) + int'(evt[3]);
         @(negedge clk);
      end
      chk("R3 count sequence mismatches", bad, 0);
      chk("R3 tio0 high samples", hi, 9);
      chk("R3 duty strobes", na, 3);
      chk("R3 period strobes", nb, 3);
      chk("R3 C/D strobes", ncd, 0);
      chk("R3 tio1 high samples", n1, 0);
   endtask

   task automatic t_prescale();
      int v, w, bad = 0, hi = 0, na = 0, nb = 0;
      halt_clear();
      wr(RA_PSC, 16'd2);
      wr(RA_PER, 16'd4);
      wr(RA_DUTY, 16'd2);
      wr(RA_CTRL, 16'h0004);
      for (int i = 0; i < 30; i++) begin
         rd(RA_COUNT, v);
         if (v != (i / 3) % 5) bad++;
         hi += int'(tio0_out);
         na += int'(evt[0]);
         nb += int'(evt[1]);
         @(negedge clk);
      end
      chk("R2 prescaled count mismatches", bad, 0);
      chk("R2 prescaled duty strobes", na, 2);
      chk("R2 prescaled period strobes", nb, 2);
      chk("R2 prescaled tio0 high samples", hi, 12);
      wr(RA_CTRL, 16'h0000);
      rd(RA_COUNT, v);
      repeat (6) @(negedge clk);
      rd(RA_COUNT, w);
      chk("R2 count holds with run clear", w, v);
      wr(RA_PSC, 16'd0);
   endtask

   task automatic t_split();
      int v, bad = 0, h0 = 0, h1 = 0;
      int ne[4] = '{0, 0, 0, 0};
      halt_clear();
      wr(RA_PER, 16'h0402);
      wr(RA_DUTY, 16'h0201);
      wr(RA_CTRL, 16'h0005);
      for (int i = 0; i < 30; i++) begin
         rd(RA_COUNT, v);
         if (v != (((i % 5) << 8) | (i % 3))) bad++;
         h0 += int'(tio0_out);
         h1 += int'(tio1_out);
         for (int e = 0; e < 4; e++) ne[e] += int'(evt[e]);
         @(negedge clk);
      end
      chk("R4 split count mismatches", bad, 0);
      chk("R4 low half output samples", h0, 10);
      chk("R4 high half output samples", h1, 12);
      chk("R4 low duty strobes", ne[0], 10);
      chk("R4 low period strobes", ne[1], 10);
      chk("R4 high duty strobes", ne[2], 6);
      chk("R4 high period strobes", ne[3], 6);
   endtask

   task automatic t_capture();
      int v, na = 0, nb = 0, nd = 0, ka = -1, kb = -1;
      halt_clear();
      tio0_in = 1'b0;
      tio1_in = 1'b1;
      wr(RA_EDGE, 16'h0009);
      repeat (4) @(negedge clk);
      wr(RA_DUTY, 16'd0);
      wr(RA_PER, 16'd0);
      wr(RA_CTRL, 16'h0016);
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         if (k == 5) tio0_in = 1'b1;
         if (k == 20) tio1_in = 1'b0;
         if (evt[0]) begin na++; ka = k; end
         if (evt[1]) begin nb++; kb = k; end
         nd += int'(evt[3]);
         if (k == 30) begin
            rd(RA_COUNT, v);
            chk("R6 count after pin-1 restart", v, 7);
         end
      end
      rd(RA_DUTY, v);
      chk("R5 rising capture into duty", v, 7);
      rd(RA_PER, v);
      chk("R5 falling capture into period", v, 22);
      chk("R5 pin-0 capture strobes", na, 1);
      chk("R5 pin-0 strobe cycle", ka, 7);
      chk("R5 pin-1 capture strobes", nb, 1);
      chk("R5 pin-1 strobe cycle", kb, 22);
      chk("R7 D strobes in capture", nd, 0);
   endtask

   task automatic t_overflow();
      int v, nc = 0, kc = -1;
      halt_clear();
      wr(RA_EDGE, 16'h0000);
      wr(RA_COUNT, 16'hFFFD);
      wr(RA_CTRL, 16'h0006);
      for (int k = 0; k <= 4; k++) begin
         if (evt[2]) begin nc++; kc = k; end
         if (k < 4) @(negedge clk);
      end
      rd(RA_COUNT, v);
      chk("R7 overflow strobes", nc, 1);
      chk("R7 overflow strobe cycle", kc, 2);
      chk("R7 count after wrap", v, 1);
   endtask

   task automatic t_freeze();
      int v, ne = 0, na = 0;
      halt_clear();
      wr(RA_PER, 16'd100);
      wr(RA_DUTY, 16'd50);
      wr(RA_CTRL, 16'h0004);
      repeat (5) @(negedge clk);
      freeze = 1'b1;
      repeat (10) begin
         @(negedge clk);
         ne += int'(evt != 4'b0000);
      end
      rd(RA_COUNT, v);
      chk("R10 count held in freeze", v, 5);
      chk("R10 strobes in freeze", ne, 0);
      freeze = 1'b0;
      repeat (3) @(negedge clk);
      rd(RA_COUNT, v);
      chk("R10 count resumes after freeze", v, 8);
      halt_clear();
      wr(RA_EDGE, 16'h0001);
      tio0_in = 1'b0;
      repeat (5) @(negedge clk);
      wr(RA_DUTY, 16'h0033);
      wr(RA_CTRL, 16'h0006);
      freeze = 1'b1;
      tio0_in = 1'b1;
      repeat (8) begin
         @(negedge clk);
         na += int'(evt[0]);
      end
      rd(RA_COUNT, v);
      chk("R10 capture-mode count held in freeze", v, 0);
      freeze = 1'b0;
      repeat (6) begin
         @(negedge clk);
         na += int'(evt[0]);
      end
      rd(RA_DUTY, v);
      chk("R10 edge in freeze not captured", v, 16'h0033);
      chk("R10 capture strobes around freeze", na, 0);
   endtask

   task automatic t_lowpwr();
      int v;
      halt_clear();
      wr(RA_EDGE, 16'h0000);
      wr(RA_PER, 16'd50);
      wr(RA_DUTY, 16'd20);
      wr(RA_CTRL, 16'h0004);
      repeat (5) @(negedge clk);
      lowpwr = 1'b1;
      repeat (2) @(negedge clk);
      wr(RA_COUNT, 16'd77);
      wr(RA_PER, 16'd3);
      wr(RA_DUTY, 16'd4);
      wr(RA_PSC, 16'd5);
      wr(RA_EDGE, 16'd3);
      rd(RA_COUNT, v);
      chk("R8 count parked in low power", v, 5);
      rd(RA_PER, v);
      chk("R9 period write ignored", v, 50);
      rd(RA_DUTY, v);
      chk("R9 duty write ignored", v, 20);
      rd(RA_PSC, v);
      chk("R8 prescale write accepted", v, 5);
      rd(RA_EDGE, v);
      chk("R8 edge write accepted", v, 3);
      wr(RA_CTRL, 16'h0000);
      rd(RA_CTRL, v);
      chk("R8 control write accepted", v, 0);
      lowpwr = 1'b0;
      wr(RA_PSC, 16'd0);
      wr(RA_EDGE, 16'd0);
   endtask

   task automatic t_partial();
      int v;
      wr(RA_PER, 16'h1234, 2'b01);
      rd(RA_PER, v);
      chk("R11 partial write to period ignored", v, 50);
      wr(RA_CTRL, 16'h0004, 2'b10);
      rd(RA_CTRL, v);
      chk("R11 partial write to control ignored", v, 0);
      wr(RA_PER, 16'h1234);
      rd(RA_PER, v);
      chk("R11 full write to period", v, 16'h1234);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pwm16();
      t_prescale();
      t_split();
      t_capture();
      t_overflow();
      t_freeze();
      t_lowpwr();
      t_partial();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule